// File: doc/BRIEF.md
# Reference Timebase Cycle and Seconds Counter

This block keeps time from a fixed 25 MHz reference clock. It holds two free-running counters. The first is a sub-second cycle count that moves in coarse steps: it advances by 16 once every 16 reference cycles (every 640 ns), so its four low bits always read zero. It returns to zero on reaching 25,000,000, which happens exactly once per second. The second counter gives the whole seconds elapsed, and it advances on every such return to zero.

Both counters start again from zero on cold reset. Software reads them through a simple 32-bit register port. A read strobe captures the selected word into a holding register in one clock edge, so a value can never be torn across a counter update. Neither counter can be written. A write strobe on any word is accepted and discarded. The wrap point and the seconds width are parameters, so a smaller instance can model a shorter "second".

Top module: `refclk_timebase`

## Requirements
- R1: After cold reset (`rst_n` low), both counters are zero and `rd_data` reads zero.
- R2: The cycle count changes only once every 16 reference cycles, each time by exactly +16, so bits [3:0] of the cycle word are always zero. After n clock edges out of reset the count is 16*floor(n/16) modulo the wrap value.
- R3: When the cycle count would reach `WRAP_CYCLES`, it returns to 0 instead. The default wrap value is 25,000,000, which must be a multiple of 16.
- R4: The seconds count increments by one in the same cycle that the cycle count wraps, and it is otherwise unchanged. After n edges it equals floor(n / `WRAP_CYCLES`).
- R5: The seconds count is `SEC_W` bits wide (default 32) and rolls over from all-ones to zero without any other effect.
- R6: When `rd_en` is high at a rising edge, `rd_data` loads the word selected by `addr`, using the counter values from just before that edge. Word 0 is the cycle count and word 1 is the seconds count, both zero-extended to 32 bits. When `rd_en` is low, `rd_data` holds its value.
- R7: A read of any word index other than 0 or 1 returns zero.
- R8: `wr_en` with any `addr` and any `wr_data` has no effect on either counter or on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| addr | input | ADDR_W | Word index for the access |
| rd_en | input | 1 | Read strobe: captures the selected word |
| wr_en | input | 1 | Write strobe (accepted, discarded) |
| wr_data | input | 32 | Write data (ignored) |
| rd_data | output | 32 | Captured read word |

## Verification
The bench makes the second short (320 cycles) and the seconds counter 4 bits wide. This lets the run cross many cycle-count wraps and one seconds rollover. A counter that wrapped one step late would show 320 instead of 0. A counter with an off-by-one compare on the seconds increment would lag the model by one second after the first wrap. A design that captured the post-edge value, or that let a write land on the counter word, would differ from the edge-counting reference model on the very cycle concerned. Reading unmapped words and holding `rd_data` with the strobe low expose a mux that leaks a counter or a read register that follows the counters.

// File: rtl/rtb_pkg.sv
package rtb_pkg;

  localparam int unsigned RTB_WORD_CYCLE   = 0;
  localparam int unsigned RTB_WORD_SECONDS = 1;

  // Next value of the coarse cycle count, wrapping at the limit.
  function automatic logic [31:0] rtb_subsec_next(input logic [31:0] cur,
                                                  input logic [31:0] step,
                                                  input logic [31:0] limit);
    logic [31:0] sum;
    sum = cur + step;
    return (sum >= limit) ? 32'd0 : sum;
  endfunction

  // True when the current count is the last one before the wrap.
  function automatic logic rtb_is_last(input logic [31:0] cur,
                                       input logic [31:0] step,
                                       input logic [31:0] limit);
    return (cur + step) >= limit;
  endfunction

endpackage

// File: rtl/rtb_prescaler.sv
module rtb_prescaler #(
  parameter int unsigned LOG2_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [LOG2_DIV-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  assign tick = &pre_q;

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2
endmodule

// File: rtl/rtb_subsec_counter.sv
module rtb_subsec_counter
  import rtb_pkg::*;
#(
  parameter int unsigned STEP        = 16,
  parameter int unsigned WRAP_CYCLES = 25000000,
  parameter int unsigned CYC_W       = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CYC_W-1:0] cyc_q,
  output logic             wrap_evt
);
  localparam logic [31:0] STEP32 = 32'(STEP);
  localparam logic [31:0] LIM32  = 32'(WRAP_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cyc_q <= '0;
    else if (tick) cyc_q <= CYC_W'(rtb_subsec_next(32'(cyc_q), STEP32, LIM32));
  end

  assign wrap_evt = tick && rtb_is_last(32'(cyc_q), STEP32, LIM32);

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q[3:0] == 4'd0); // R2
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cyc_q)); // R2
  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap_evt) |=> (32'(cyc_q) == 32'($past(cyc_q)) + STEP32)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cyc_q == '0)); // R3
  AST_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cyc_q) < LIM32); // R3
endmodule

// File: rtl/rtb_seconds_counter.sv
module rtb_seconds_counter #(
  parameter int unsigned SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap_evt,
  output logic [SEC_W-1:0] sec_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sec_q <= '0;
    else if (wrap_evt) sec_q <= sec_q + 1'b1;
  end

  AST_SEC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (sec_q == $past(sec_q) + 1'b1)); // R4
  AST_SEC_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> $stable(sec_q)); // R4
  AST_SEC_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && (&sec_q)) |=> (sec_q == '0)); // R5
endmodule

// File: rtl/rtb_read_port.sv
module rtb_read_port
  import rtb_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned CYC_W  = 25,
  parameter int unsigned SEC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic [CYC_W-1:0]  cyc_val,
  input  logic [SEC_W-1:0]  sec_val,
  output logic [31:0]       rd_data
);
  logic [31:0] sel_word;

  always_comb begin
    if (32'(addr) == RTB_WORD_CYCLE)        sel_word = 32'(cyc_val);
    else if (32'(addr) == RTB_WORD_SECONDS) sel_word = 32'(sec_val);
    else                                    sel_word = 32'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= 32'd0;
    else if (rd_en) rd_data <= sel_word;
  end

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (32'(addr) > RTB_WORD_SECONDS)) |=> (rd_data == 32'd0)); // R7
endmodule

// File: rtl/refclk_timebase.sv
module refclk_timebase #(
  parameter int unsigned WRAP_CYCLES = 25000000,
  parameter int unsigned SEC_W       = 32,
  parameter int unsigned ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data
);
  localparam int unsigned LOG2_DIV = 4;
  localparam int unsigned STEP     = 1 << LOG2_DIV;
  localparam int unsigned CYC_W    = $clog2(WRAP_CYCLES);

  logic             tick;
  logic             wrap_evt;
  logic [CYC_W-1:0] cyc_q;
  logic [SEC_W-1:0] sec_q;
  logic             wr_unused;

  // The write channel exists only to be discarded.
  assign wr_unused = ^{wr_en, wr_data};

  rtb_prescaler #(.LOG2_DIV(LOG2_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  rtb_subsec_counter #(.STEP(STEP), .WRAP_CYCLES(WRAP_CYCLES), .CYC_W(CYC_W)) u_sub (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cyc_q(cyc_q), .wrap_evt(wrap_evt)
  );

  rtb_seconds_counter #(.SEC_W(SEC_W)) u_sec (
    .clk(clk), .rst_n(rst_n), .wrap_evt(wrap_evt), .sec_q(sec_q)
  );

  rtb_read_port #(.ADDR_W(ADDR_W), .CYC_W(CYC_W), .SEC_W(SEC_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
    .cyc_val(cyc_q), .sec_val(sec_q), .rd_data(rd_data)
  );

  AST_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en) |=> $stable(rd_data)); // R8
endmodule

// File: tb/sim_refclk_timebase.sv
module sim_refclk_timebase;
  localparam int unsigned WRAP = 320;
  localparam int unsigned SW   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = 32'd0;
  logic [31:0] rd_data;

  int unsigned n_checks = 0;
  int unsigned n_fail = 0;
  int unsigned edges = 0;
  logic [31:0] exp_rd = 32'd0;
  bit          running = 1'b0;
  bit          finished = 1'b0;
  string       cur_req = "R1";

  refclk_timebase #(.WRAP_CYCLES(WRAP), .SEC_W(SW), .ADDR_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  always #2 clk = ~clk;

  // Reference: counters as a function of edges since reset.
  function automatic logic [31:0] model_word(input int unsigned a, input int unsigned n);
    int unsigned coarse, secs;
    coarse = ((n / 16) * 16) % WRAP;
    secs   = (n / WRAP) % (1 << SW);
    if (a == 0) return 32'(coarse);
    if (a == 1) return 32'(secs);
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      edges  = 0;
      exp_rd = 32'd0;
    end else begin
      if (rd_en) exp_rd = model_word(32'(addr), edges);
      edges = edges + 1;
    end
  end

  always @(negedge clk) begin
    if (running && !finished) begin
      n_checks++;
      if (rd_data !== exp_rd) begin
        n_fail++;
        $display("FAIL %s edge=%0d addr=%0d actual=%0d expected=%0d",
                 cur_req, edges, addr, rd_data, exp_rd);
      end
    end
  end

  task automatic run(input int unsigned cycles);
    for (int i = 0; i < cycles; i++) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    running = 1'b1;
    run(3);
    rst_n = 1'b1;
    // R2: coarse steps of 16, low bits zero
    cur_req = "R2"; addr = 2'd0; rd_en = 1'b1;
    run(40);
    // R6: read register holds without strobe
    cur_req = "R6"; rd_en = 1'b0;
    run(10);
    // R3: cross the wrap of the cycle count
    cur_req = "R3"; rd_en = 1'b1; addr = 2'd0;
    run(400);
    // R4: alternate words across several seconds
    cur_req = "R4";
    for (int i = 0; i < 700; i++) begin
      addr = 2'(i % 2);
      @(negedge clk);
    end
    // R7: unmapped words read zero
    cur_req = "R7";
    for (int i = 0; i < 20; i++) begin
      addr = 2'd2 + 2'(i % 2);
      @(negedge clk);
    end
    // R8: writes discarded, with and without a read in the same cycle
    cur_req = "R8"; wr_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      addr    = 2'(i % 2);
      wr_data = 32'hA5A5_0000 ^ 32'(i * 7919);
      rd_en   = (i % 4) != 3;
      @(negedge clk);
    end
    wr_en = 1'b0; rd_en = 1'b1;
    // R5: seconds count rolls over silently
    cur_req = "R5"; addr = 2'd1;
    run(4200);
    // R1: mid-run cold reset
    cur_req = "R1"; rst_n = 1'b0;
    run(3);
    rst_n = 1'b1; addr = 2'd0;
    run(20);
    addr = 2'd1;
    run(5);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule